// File: doc/BRIEF.md
# Core Permission and Delegation Unit

This block keeps the identity of one core: its own address and its own permission mask. It also keeps the address and permission that the core will hand to any core it starts. The delegated pair can only narrow what the core itself holds. Every bit set in the core's own mask stays set in the delegated mask. Every address bit under that mask is pinned to the core's own address.

The block also judges privilege over a target core, using the address that the target's bus reports. From that it decides whether a start (incept) or stop (kill) request may act. A stop aimed at a core outside the core's privilege does nothing, but it still reports success to the issuer. A start may act on an idle target, or on a running target that the core has privilege over. Four readback operations return the core's own permission and address, or the target bus's permission and address. Each value is zero-extended into a data word, one cycle after the request.

The operation code arrives with a valid strobe. The privilege flag and the grant are combinational. Register updates, readback data and the completion report take effect on the next rising clock edge.

Top module: `perm_deleg_unit`

## Requirements
- R1: After reset, own and delegated permission equal parameter RST_PERM, own and delegated address equal RST_ADDR, and rd_valid and act_done are 0.
- R2: tgt_priv is 1 exactly when (tgt_addr AND own permission) equals (own address AND own permission). It is combinational.
- R3: Operation code 1 (set delegation) with op_valid loads the delegated permission with own permission OR opnd_perm on the next edge.
- R4: Operation code 1 loads the delegated address with (own address AND own permission) OR (opnd_addr AND NOT own permission).
- R5: Operation code 8 (adopt, used when the core is itself started) loads own permission and delegated permission from opnd_perm. It loads own address and delegated address from opnd_addr.
- R6: While op_valid is 1 with code 6 (incept), grant is 1 exactly when tgt_running is 0 or tgt_priv is 1.
- R7: While op_valid is 1 with code 7 (kill), grant equals tgt_priv. grant is 0 for every other code and whenever op_valid is 0.
- R8: One cycle after a valid code 6 or 7, act_done is 1. act_ok is 1 for a kill regardless of privilege. For an incept, act_ok equals the grant of that cycle.
- R9: One cycle after a valid code 3, rd_valid is 1 and rd_data holds the own address zero-extended, in the least significant bits.
- R10: One cycle after a valid code 2, 4 or 5, rd_valid is 1 and rd_data holds, zero-extended, the own permission (code 2), tgt_perm (code 4) or tgt_addr (code 5).
- R11: Operations other than codes 1 and 8 leave the delegated permission and address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation code |
| opnd_perm | input | AW | Permission operand |
| opnd_addr | input | AW | Address operand |
| tgt_addr | input | AW | Address reported by the target bus |
| tgt_perm | input | AW | Permission reported by the target bus |
| tgt_running | input | 1 | Target core is running |
| tgt_priv | output | 1 | Core has privilege over the target |
| grant | output | 1 | Current incept/kill may act |
| dlg_perm | output | AW | Delegated permission |
| dlg_addr | output | AW | Delegated address |
| rd_data | output | DW | Readback word |
| rd_valid | output | 1 | Readback word valid |
| act_done | output | 1 | Incept/kill completed |
| act_ok | output | 1 | Reported success of that incept/kill |

## Verification
The bench builds the unit with a 4-bit address and permission, an 8-bit data word, and reset values 4'hC and 4'h5. At that width, every own mask and own address can be adopted, and each can be compared against all sixteen target addresses, for privilege and for both grant cases. Setting delegation is swept over all operand pairs for every own mask, at two own addresses. The 8-bit word makes zero-extension of readback data visible.

// File: rtl/pdu_pkg.sv
package pdu_pkg;
  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_SETPA  = 4'd1,
    OP_GETP   = 4'd2,
    OP_GETA   = 4'd3,
    OP_GETBP  = 4'd4,
    OP_GETBA  = 4'd5,
    OP_INCEPT = 4'd6,
    OP_KILL   = 4'd7,
    OP_ADOPT  = 4'd8
  } pdu_op_e;
endpackage

// File: rtl/pdu_regs.sv
module pdu_regs #(
  parameter int AW = 32,
  parameter logic [AW-1:0] RST_PERM = '1,
  parameter logic [AW-1:0] RST_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_adopt,
  input  logic          ld_setpa,
  input  logic [AW-1:0] in_perm,
  input  logic [AW-1:0] in_addr,
  output logic [AW-1:0] own_perm,
  output logic [AW-1:0] own_addr,
  output logic [AW-1:0] dlg_perm,
  output logic [AW-1:0] dlg_addr
);
  logic [AW-1:0] narrow_perm;
  logic [AW-1:0] narrow_addr;

  // delegation may only restrict: mask grows, masked address bits pinned
  assign narrow_perm = own_perm | in_perm;
  assign narrow_addr = (own_addr & own_perm) | (in_addr & ~own_perm);

  always_ff @(posedge clk) begin
    if (rst) begin
      own_perm <= RST_PERM;
      own_addr <= RST_ADDR;
      dlg_perm <= RST_PERM;
      dlg_addr <= RST_ADDR;
    end else if (ld_adopt) begin
      own_perm <= in_perm;
      own_addr <= in_addr;
      dlg_perm <= in_perm;
      dlg_addr <= in_addr;
    end else if (ld_setpa) begin
      dlg_perm <= narrow_perm;
      dlg_addr <= narrow_addr;
    end
  end
endmodule

// File: rtl/pdu_priv.sv
module pdu_priv #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] own_perm,
  input  logic [AW-1:0] own_addr,
  input  logic [AW-1:0] tgt_addr,
  input  logic          tgt_running,
  input  logic          req_incept,
  input  logic          req_kill,
  output logic          priv,
  output logic          allow
);
  logic [AW-1:0] diff;

  assign diff  = (tgt_addr ^ own_addr) & own_perm;
  assign priv  = (diff == '0);
  assign allow = (req_incept & (~tgt_running | priv)) | (req_kill & priv);
endmodule

// File: rtl/pdu_rdback.sv
module pdu_rdback
  import pdu_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  pdu_op_e       op,
  input  logic [AW-1:0] own_perm,
  input  logic [AW-1:0] own_addr,
  input  logic [AW-1:0] tgt_perm,
  input  logic [AW-1:0] tgt_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic [AW-1:0] src;
  logic          hit;

  always_comb begin
    hit = 1'b1;
    unique case (op)
      OP_GETP:  src = own_perm;
      OP_GETA:  src = own_addr;
      OP_GETBP: src = tgt_perm;
      OP_GETBA: src = tgt_addr;
      default: begin
        src = '0;
        hit = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= valid & hit;
      if (valid & hit) rd_data <= DW'(src);
    end
  end
endmodule

// File: rtl/perm_deleg_unit.sv
module perm_deleg_unit
  import pdu_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [AW-1:0] RST_PERM = '1,
  parameter logic [AW-1:0] RST_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [3:0]    op_code,
  input  logic [AW-1:0] opnd_perm,
  input  logic [AW-1:0] opnd_addr,
  input  logic [AW-1:0] tgt_addr,
  input  logic [AW-1:0] tgt_perm,
  input  logic          tgt_running,
  output logic          tgt_priv,
  output logic          grant,
  output logic [AW-1:0] dlg_perm,
  output logic [AW-1:0] dlg_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          act_done,
  output logic          act_ok
);
  pdu_op_e       op;
  logic          is_incept, is_kill;
  logic [AW-1:0] own_perm, own_addr;

  assign op        = pdu_op_e'(op_code);
  assign is_incept = op_valid && (op == OP_INCEPT);
  assign is_kill   = op_valid && (op == OP_KILL);

  pdu_regs #(.AW(AW), .RST_PERM(RST_PERM), .RST_ADDR(RST_ADDR)) regs_i (
    .clk(clk), .rst(rst),
    .ld_adopt(op_valid && (op == OP_ADOPT)),
    .ld_setpa(op_valid && (op == OP_SETPA)),
    .in_perm(opnd_perm), .in_addr(opnd_addr),
    .own_perm(own_perm), .own_addr(own_addr),
    .dlg_perm(dlg_perm), .dlg_addr(dlg_addr)
  );

  pdu_priv #(.AW(AW)) priv_i (
    .own_perm(own_perm), .own_addr(own_addr),
    .tgt_addr(tgt_addr), .tgt_running(tgt_running),
    .req_incept(is_incept), .req_kill(is_kill),
    .priv(tgt_priv), .allow(grant)
  );

  pdu_rdback #(.AW(AW), .DW(DW)) rdb_i (
    .clk(clk), .rst(rst), .valid(op_valid), .op(op),
    .own_perm(own_perm), .own_addr(own_addr),
    .tgt_perm(tgt_perm), .tgt_addr(tgt_addr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // kill reports success even when it was not permitted to act
  always_ff @(posedge clk) begin
    if (rst) begin
      act_done <= 1'b0;
      act_ok   <= 1'b0;
    end else begin
      act_done <= is_incept | is_kill;
      act_ok   <= is_kill | (is_incept & grant);
    end
  end
endmodule

// File: rtl/pdu_checker.sv
module pdu_checker #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic [3:0]    op_code,
  input logic          tgt_running,
  input logic          tgt_priv,
  input logic          grant,
  input logic [AW-1:0] own_perm,
  input logic [AW-1:0] own_addr,
  input logic [AW-1:0] dlg_perm,
  input logic [AW-1:0] dlg_addr,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid,
  input logic          act_done,
  input logic          act_ok
);
  p_narrow_perm_r3: assert property (@(posedge clk) disable iff (rst)
    (dlg_perm & own_perm) == own_perm);

  p_pinned_addr_r4: assert property (@(posedge clk) disable iff (rst)
    (dlg_addr & own_perm) == (own_addr & own_perm));

  p_idle_incept_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd6 && !tgt_running) |-> grant);

  p_kill_needs_priv_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd7 && grant) |-> tgt_priv);

  p_no_grant_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !op_valid |-> !grant);

  p_kill_ok_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd7) |=> (act_done && act_ok));

  p_geta_rd_r9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd3) |=> (rd_valid && rd_data == DW'($past(own_addr))));

  p_dlg_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && (op_code == 4'd1 || op_code == 4'd8)) |=> ($stable(dlg_perm) && $stable(dlg_addr)));
endmodule

bind perm_deleg_unit pdu_checker #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .tgt_running(tgt_running), .tgt_priv(tgt_priv), .grant(grant),
  .own_perm(own_perm), .own_addr(own_addr),
  .dlg_perm(dlg_perm), .dlg_addr(dlg_addr),
  .rd_data(rd_data), .rd_valid(rd_valid),
  .act_done(act_done), .act_ok(act_ok)
);

// File: tb/perm_deleg_unit_tb_top.sv
`timescale 1ns/100ps
module perm_deleg_unit_tb_top;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam logic [AW-1:0] RP = 4'hC;
  localparam logic [AW-1:0] RA = 4'h5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic [3:0]    op_code = 4'd0;
  logic [AW-1:0] opnd_perm = '0, opnd_addr = '0, tgt_addr = '0, tgt_perm = '0;
  logic          tgt_running = 1'b0;
  logic          tgt_priv, grant, rd_valid, act_done, act_ok;
  logic [AW-1:0] dlg_perm, dlg_addr;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  perm_deleg_unit #(.AW(AW), .DW(DW), .RST_PERM(RP), .RST_ADDR(RA)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .opnd_perm(opnd_perm), .opnd_addr(opnd_addr),
    .tgt_addr(tgt_addr), .tgt_perm(tgt_perm), .tgt_running(tgt_running),
    .tgt_priv(tgt_priv), .grant(grant),
    .dlg_perm(dlg_perm), .dlg_addr(dlg_addr),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .act_done(act_done), .act_ok(act_ok)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, let one posedge pass, return at the next negedge
  task automatic do_op(input logic [3:0] code, input logic [AW-1:0] p, input logic [AW-1:0] a);
    op_code = code; opnd_perm = p; opnd_addr = a; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    #1;
  endtask

  function automatic bit exp_priv(input int t, input int oa, input int p);
    return ((t ^ oa) & p) == 0;
  endfunction

  initial begin
    #(8 * 190000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk(dlg_perm == RP, "R1 dlg_perm", dlg_perm, RP);
    chk(dlg_addr == RA, "R1 dlg_addr", dlg_addr, RA);
    chk(!rd_valid && !act_done, "R1 idle outputs", {rd_valid, act_done}, 0);
    @(negedge clk);
    do_op(4'd2, 0, 0);
    chk(rd_valid && rd_data == DW'(RP), "R10 getp after reset", rd_data, RP);
    @(negedge clk);
    do_op(4'd3, 0, 0);
    chk(rd_valid && rd_data == DW'(RA), "R9 geta after reset", rd_data, RA);
    @(negedge clk);

    // R2/R5/R6/R7 sweep over own mask, own address, target address
    for (int p = 0; p < 16; p++) begin
      for (int oa = 0; oa < 16; oa++) begin
        do_op(4'd8, 4'(p), 4'(oa));
        chk(dlg_perm == 4'(p) && dlg_addr == 4'(oa), "R5 adopt", {dlg_perm, dlg_addr}, {p[3:0], oa[3:0]});
        for (int t = 0; t < 16; t++) begin
          @(negedge clk);
          tgt_addr = 4'(t); op_code = 4'd6; tgt_running = 1'b1; op_valid = 1'b1;
          #0.5;
          chk(tgt_priv == exp_priv(t, oa, p), "R2 priv", tgt_priv, exp_priv(t, oa, p));
          chk(grant == exp_priv(t, oa, p), "R6 incept running", grant, exp_priv(t, oa, p));
          tgt_running = 1'b0; #0.5;
          chk(grant == 1'b1, "R6 incept idle", grant, 1);
          op_code = 4'd7; tgt_running = 1'b1; #0.5;
          chk(grant == exp_priv(t, oa, p), "R7 kill", grant, exp_priv(t, oa, p));
          op_valid = 1'b0; #0.5;
          chk(grant == 1'b0, "R7 no strobe", grant, 0);
        end
        @(negedge clk);
      end
    end

    // R8 completion reports; own mask F, address 3
    do_op(4'd8, 4'hF, 4'h3);
    tgt_addr = 4'h9; tgt_running = 1'b1;
    @(negedge clk);
    do_op(4'd7, 0, 0);
    chk(act_done && act_ok, "R8 kill without priv ok", {act_done, act_ok}, 3);
    do_op(4'd6, 0, 0);
    chk(act_done && !act_ok, "R8 incept refused", {act_done, act_ok}, 2);
    tgt_running = 1'b0;
    do_op(4'd6, 0, 0);
    chk(act_done && act_ok, "R8 incept idle target", {act_done, act_ok}, 3);
    tgt_addr = 4'h3; tgt_running = 1'b1;
    do_op(4'd6, 0, 0);
    chk(act_done && act_ok, "R8 incept with priv", {act_done, act_ok}, 3);
    do_op(4'd2, 0, 0);
    chk(!act_done, "R8 done only for incept/kill", act_done, 0);

    // R3/R4 sweep of delegation operands
    for (int k = 0; k < 2; k++) begin
      for (int p = 0; p < 16; p++) begin
        int oa;
        oa = (k == 0) ? 5 : 10;
        do_op(4'd8, 4'(p), 4'(oa));
        for (int pp = 0; pp < 16; pp++) begin
          for (int aa = 0; aa < 16; aa++) begin
            int ep, ea;
            ep = (p | pp) & 15;
            ea = ((oa & p) | (aa & ~p)) & 15;
            do_op(4'd1, 4'(pp), 4'(aa));
            chk(dlg_perm == 4'(ep), "R3 setpa perm", dlg_perm, ep);
            chk(dlg_addr == 4'(ea), "R4 setpa addr", dlg_addr, ea);
          end
        end
      end
    end

    // R11 other ops keep delegation
    do_op(4'd8, 4'h3, 4'h6);
    do_op(4'd1, 4'h8, 4'h9);
    tgt_perm = 4'hA; tgt_addr = 4'h7;
    for (int c = 0; c < 8; c++) begin
      if (c == 1) continue;
      do_op(4'(c), 4'hF, 4'hF);
      chk(dlg_perm == 4'hB && dlg_addr == 4'hA, "R11 hold", {dlg_perm, dlg_addr}, 8'hBA);
    end

    // R9/R10 readback
    do_op(4'd3, 0, 0);
    chk(rd_valid && rd_data == 8'h06, "R9 geta zero-extended", rd_data, 8'h06);
    do_op(4'd2, 0, 0);
    chk(rd_valid && rd_data == 8'h03, "R10 getp", rd_data, 8'h03);
    do_op(4'd4, 0, 0);
    chk(rd_valid && rd_data == 8'h0A, "R10 target perm", rd_data, 8'h0A);
    do_op(4'd5, 0, 0);
    chk(rd_valid && rd_data == 8'h07, "R10 target addr", rd_data, 8'h07);
    do_op(4'd0, 0, 0);
    chk(!rd_valid, "R10 no readback on nop", rd_valid, 0);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule